// File: doc/BRIEF.md
# CAN Frame to Transmit-FIFO Byte Serializer

This block takes one CAN frame and turns it into the ordered byte stream that a CAN controller with a serial host port expects when its transmit FIFO is loaded. A frame is a 29-bit identifier, with only the low 11 bits used for base-format frames, together with an extended-format flag, a remote-request flag, a length and up to eight payload bytes. The frame is taken in with a valid/ready handshake. The block copies it into a small byte buffer and then presents it one byte per handshake on an output stream that carries a last marker.

The stream always opens with the FIFO-write opcode and a zero tag byte. Next come the identifier bytes in the controller's own packing. An extended identifier is four bytes and has two fixed recessive bits, the substitute-remote and extension flags, placed inside its second byte. The length byte follows, then exactly as many payload bytes as the length gives. The stream length therefore depends on both the frame format and the payload size. A downstream serial shifter consumes the stream and controls chip select.

Top module: `can_fifo_serializer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Asserting reset during a stream drops that stream and returns the block to this state.
- R2: A frame is taken on a cycle with `in_valid` and `in_ready` both high. `in_ready` stays low while any byte of that frame is still pending and returns high in the cycle after the final byte is taken.
- R3: Stream byte 0 is 0x12, the FIFO-write opcode, and it is presented in the cycle right after acceptance. Byte 1 is the tag 0x00.
- R4: When `in_ext`=0, bytes 2 and 3 are ID[10:3] and {ID[2:0], RTR, 4'b0000}. ID bits 28..11 have no effect.
- R5: When `in_ext`=1, bytes 2 to 5 are ID[28:21], {ID[20:18], 1, 1, ID[17:15]}, ID[14:7] and {ID[6:0], RTR}.
- R6: The length byte, zero-extended, comes at stream index 4 for base frames and index 6 for extended frames. Payload bytes follow in order, with `in_data[7:0]` first.
- R7: A base frame is 5+len bytes long and an extended frame is 7+len bytes long. `out_last` is high on the final byte only.
- R8: A length above 8 is treated as 8, both in the length byte and in the number of payload bytes sent.
- R9: While `out_valid` is high and `out_ready` is low, `out_byte`, `out_last` and `out_valid` hold their values.
- R10: With length 0, the length byte is the final byte and carries `out_last`.
- R11: Changes on the frame inputs after acceptance have no effect on the stream in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame offered |
| in_ready | output | 1 | Block can take a frame |
| in_ext | input | 1 | 1 = 29-bit identifier, 0 = 11-bit |
| in_rtr | input | 1 | Remote-request flag |
| in_id | input | 29 | Identifier (low 11 bits for base frames) |
| in_len | input | 4 | Payload length, values above 8 clamped |
| in_data | input | 64 | Payload, byte 0 in bits 7:0 |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The bench aims at four weak spots. The first is the placement of the two fixed bits inside the extended identifier: a wrong shift there corrupts the identifier bits beside them, and a missing OR leaves 0x18 out. The second is an off-by-one in the stream length, which shows up as a dropped last payload byte or a stray extra byte, most clearly with zero-length and full-length frames. The third is a clamp that is missing or applied to only one of the length byte and the byte count, so that a 12- or 15-byte request produces a stream that does not match its own length byte. The fourth covers backpressure that changes the byte while it is stalled, and identifier bits above 10 that leak into base frames.

// File: rtl/can_ser_pkg.sv
package can_ser_pkg;
  localparam logic [7:0] WR_FIFO_OP = 8'h12;
  localparam logic [7:0] TAG_BYTE   = 8'h00;
  localparam logic [1:0] SRR_IDE    = 2'b11;
  localparam int         ID_W       = 29;
  localparam int         STD_HDR    = 5;   // opcode, tag, 2 id, length
  localparam int         EXT_HDR    = 7;   // opcode, tag, 4 id, length
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/can_ser_pack.sv
module can_ser_pack
  import can_ser_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int LEN_W      = 4,
  parameter int BUF_BYTES  = DATA_BYTES + EXT_HDR,
  parameter int CNT_W      = $clog2(BUF_BYTES + 1)
) (
  input  logic                    ext_i,
  input  logic                    rtr_i,
  input  logic [ID_W-1:0]         id_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic [8*DATA_BYTES-1:0] data_i,
  output byte_t                   bytes_o [BUF_BYTES],
  output logic [CNT_W-1:0]        nbytes_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_BYTES);

  logic [LEN_W-1:0] len_c;
  byte_t            len_byte;

  always_comb begin
    len_c    = (len_i > LEN_MAX) ? LEN_MAX : len_i;
    len_byte = byte_t'(len_c);
    nbytes_o = (ext_i ? CNT_W'(EXT_HDR) : CNT_W'(STD_HDR)) + CNT_W'(len_c);
  end

  for (genvar j = 0; j < BUF_BYTES; j++) begin : g_slot
    localparam int SI = j - STD_HDR;
    localparam int EI = j - EXT_HDR;
    byte_t std_b, ext_b;
    if (j == 0) begin : g_op
      assign std_b = WR_FIFO_OP;
      assign ext_b = WR_FIFO_OP;
    end else if (j == 1) begin : g_tag
      assign std_b = TAG_BYTE;
      assign ext_b = TAG_BYTE;
    end else if (j == 2) begin : g_id0
      assign std_b = id_i[10:3];
      assign ext_b = id_i[28:21];
    end else if (j == 3) begin : g_id1
      assign std_b = {id_i[2:0], rtr_i, 4'b0000};
      assign ext_b = {id_i[20:18], SRR_IDE, id_i[17:15]};
    end else begin : g_tail
      if (j == STD_HDR - 1) begin : g_slen
        assign std_b = len_byte;
      end else if (SI >= 0 && SI < DATA_BYTES) begin : g_sdat
        assign std_b = data_i[SI*8 +: 8];
      end else begin : g_spad
        assign std_b = 8'h00;
      end
      if (j == 4) begin : g_id2
        assign ext_b = id_i[14:7];
      end else if (j == 5) begin : g_id3
        assign ext_b = {id_i[6:0], rtr_i};
      end else if (j == EXT_HDR - 1) begin : g_elen
        assign ext_b = len_byte;
      end else if (EI >= 0 && EI < DATA_BYTES) begin : g_edat
        assign ext_b = data_i[EI*8 +: 8];
      end else begin : g_epad
        assign ext_b = 8'h00;
      end
    end
    assign bytes_o[j] = ext_i ? ext_b : std_b;
  end
endmodule

// File: rtl/can_ser_stream.sv
module can_ser_stream
  import can_ser_pkg::*;
#(
  parameter int BUF_BYTES = 15,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1),
  parameter int IDX_W     = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  byte_t            bytes_i [BUF_BYTES],
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             out_ready,
  output logic             out_valid,
  output byte_t            out_byte,
  output logic             out_last
);
  byte_t            buf_q [BUF_BYTES];
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] idx_q;

  // Frame buffer: plain write port, no reset, so it can map to RAM.
  always_ff @(posedge clk) begin
    if (load_i) begin
      for (int b = 0; b < BUF_BYTES; b++) buf_q[b] <= bytes_i[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_last  <= 1'b0;
      idx_q     <= '0;
      total_q   <= '0;
    end else if (load_i) begin
      out_valid <= 1'b1;
      out_byte  <= bytes_i[0];
      out_last  <= 1'b0;
      idx_q     <= CNT_W'(1);
      total_q   <= nbytes_i;
    end else if (out_valid && out_ready) begin
      if (out_last) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end else begin
        out_byte <= buf_q[idx_q[IDX_W-1:0]];
        out_last <= (idx_q == total_q - CNT_W'(1));
        idx_q    <= idx_q + CNT_W'(1);
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !load_i) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last && !load_i) |=> !out_valid);

  // R7
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (idx_q <= total_q));
endmodule

// File: rtl/can_fifo_serializer.sv
module can_fifo_serializer
  import can_ser_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int LEN_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_ext,
  input  logic                    in_rtr,
  input  logic [28:0]             in_id,
  input  logic [LEN_W-1:0]        in_len,
  input  logic [8*DATA_BYTES-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [7:0]              out_byte,
  output logic                    out_last
);
  localparam int BUF_BYTES = DATA_BYTES + EXT_HDR;
  localparam int CNT_W     = $clog2(BUF_BYTES + 1);

  byte_t            frame_bytes [BUF_BYTES];
  logic [CNT_W-1:0] frame_len;
  logic             load;

  assign in_ready = !out_valid;
  assign load     = in_valid && in_ready;

  can_ser_pack #(
    .DATA_BYTES(DATA_BYTES), .LEN_W(LEN_W),
    .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)
  ) u_pack (
    .ext_i(in_ext), .rtr_i(in_rtr), .id_i(in_id), .len_i(in_len),
    .data_i(in_data), .bytes_o(frame_bytes), .nbytes_o(frame_len)
  );

  can_ser_stream #(
    .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)
  ) u_stream (
    .clk(clk), .rst(rst), .load_i(load), .bytes_i(frame_bytes),
    .nbytes_i(frame_len), .out_ready(out_ready), .out_valid(out_valid),
    .out_byte(out_byte), .out_last(out_last)
  );

  // R3
  opcode_first_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (out_valid && out_byte == WR_FIFO_OP && !out_last));

  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R2
  free_again_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> in_ready);
endmodule

// File: tb/sim_can_fifo_serializer.sv
`timescale 1ns/1ps
module sim_can_fifo_serializer;
  typedef struct packed {
    logic        ext;
    logic        rtr;
    logic [28:0] id;
    logic [3:0]  len;
    logic [63:0] data;
    logic [3:0]  stall;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 29'h000005A3, 4'd3,  64'h00000000_00CCBBAA, 4'b0000},
    '{1'b0, 1'b1, 29'h1FFFF123, 4'd0,  64'hDEADBEEF_01234567, 4'b0101},
    '{1'b1, 1'b0, 29'h1ABCDEF5, 4'd8,  64'h88776655_44332211, 4'b0010},
    '{1'b1, 1'b1, 29'h00000001, 4'd0,  64'h0,                 4'b1100},
    '{1'b0, 1'b0, 29'h000007FF, 4'd12, 64'hF0E1D2C3_B4A59687, 4'b0000},
    '{1'b1, 1'b1, 29'h15555555, 4'd15, 64'h0102030405060708,  4'b1001},
    '{1'b0, 1'b1, 29'h00000400, 4'd8,  64'h55AA55AA_FF00FF00, 4'b0110},
    '{1'b1, 1'b0, 29'h0AAAAAAA, 4'd1,  64'h00000000_0000007E, 4'b0000}
  };

  logic        clk = 0, rst = 1;
  logic        in_valid = 0, in_ext = 0, in_rtr = 0, out_ready = 0;
  logic [28:0] in_id = '0;
  logic [3:0]  in_len = '0;
  logic [63:0] in_data = '0;
  logic        in_ready, out_valid, out_last;
  logic [7:0]  out_byte;

  int checks = 0, fails = 0;
  logic [7:0] exp_b [16];
  int exp_n;

  always #2 clk = ~clk;

  can_fifo_serializer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_ext(in_ext), .in_rtr(in_rtr), .in_id(in_id), .in_len(in_len),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic build(input vec_t v);
    int l;
    int h;
    l = (v.len > 4'd8) ? 8 : int'(v.len);
    for (int i = 0; i < 16; i++) exp_b[i] = 8'h00;
    exp_b[0] = 8'h12;
    exp_b[1] = 8'h00;
    if (v.ext) begin
      exp_b[2] = v.id[28:21];
      exp_b[3] = {v.id[20:18], 2'b11, v.id[17:15]};
      exp_b[4] = v.id[14:7];
      exp_b[5] = {v.id[6:0], v.rtr};
      h = 7;
    end else begin
      exp_b[2] = v.id[10:3];
      exp_b[3] = {v.id[2:0], v.rtr, 4'b0000};
      h = 5;
    end
    exp_b[h-1] = 8'(l);
    for (int i = 0; i < l; i++) exp_b[h+i] = v.data[i*8 +: 8];
    exp_n = h + l;
  endtask

  function automatic string req_of(input int idx, input logic ext);
    if (idx < 2) return "R3";
    if (idx < (ext ? 6 : 4)) return ext ? "R5" : "R4";
    if (idx == (ext ? 6 : 4)) return "R6_len";
    return "R6_data";
  endfunction

  task automatic run_vec(input vec_t v);
    int k = 0;
    int got = 0;
    bit done = 0;
    bit stalled = 0;
    logic [7:0] held = '0;
    build(v);
    @(negedge clk);
    in_valid = 1; in_ext = v.ext; in_rtr = v.rtr; in_id = v.id;
    in_len = v.len; in_data = v.data; out_ready = 0;
    chk(in_ready == 1'b1, "R2", 64'(in_ready), 64'd1, "ready before frame");
    @(posedge clk);
    while (!done) begin
      @(negedge clk);
      if (k == 0) begin  // R11: scramble inputs after acceptance
        in_valid = 0; in_id = ~in_id; in_data = ~in_data;
        in_len = ~in_len; in_rtr = ~in_rtr; in_ext = ~in_ext;
      end
      out_ready = !v.stall[k % 4];
      k++;
      if (!out_valid) begin
        chk(0, "R7", 64'(got), 64'(exp_n), "stream ended early");
        done = 1;
      end else begin
        chk(in_ready == 1'b0, "R2", 64'(in_ready), 64'd0, "ready while busy");
        if (stalled) chk(out_byte == held, "R9", 64'(out_byte), 64'(held), "held byte");
        if (out_ready) begin
          chk(out_byte == exp_b[got], req_of(got, v.ext), 64'(out_byte), 64'(exp_b[got]),
              $sformatf("byte %0d (R11 inputs scrambled)", got));
          chk(out_last == (got == exp_n - 1), (v.len == 0) ? "R10" : "R7",
              64'(out_last), 64'(got == exp_n - 1), $sformatf("last at %0d", got));
          if (out_last || got >= 15) done = 1;
          got++;
          stalled = 0;
        end else begin
          stalled = 1;
          held = out_byte;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    out_ready = 0;
    chk(got == exp_n, (v.len > 4'd8) ? "R8" : "R7", 64'(got), 64'(exp_n), "byte count");
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R2", 64'({out_valid, in_ready}), 64'b01,
        "idle after last");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0, "valid after reset");
    chk(in_ready == 1'b1, "R1", 64'(in_ready), 64'd1, "ready after reset");

    for (int n = 0; n < NV; n++) run_vec(VECS[n]);

    // R1 reset during a stream
    @(negedge clk);
    in_valid = 1; in_ext = 1; in_len = 4'd8; in_id = 29'h1234567;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; out_ready = 1;
    repeat (2) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0; out_ready = 0;
    chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0, "valid after mid-stream reset");
    chk(in_ready == 1'b1, "R1", 64'(in_ready), 64'd1, "ready after mid-stream reset");
    run_vec(VECS[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule